// File: doc/BRIEF.md
# Subscriber Line State Controller

This block keeps the operating state of one telephone line interface and turns it into the control levels the line driver needs: a one-hot state vector, the polarity of the feed, a high-impedance enable for each lead, an audio-path enable, a ringing enable and a supervision enable. The host requests a state by writing a 3-bit code. The controller applies it on the next clock edge.

Two fault sources can override the host. The first is an overpower alarm. The second is a die temperature code compared against a limit, and that limit is higher while the line is ringing. Either fault drops the line back to Open on its own, whatever the interrupt mask says. Each fault also sets a sticky interrupt flag. The host clears a flag by writing 1 to it. A single interrupt line reports any flag that is set and not masked.

Top module: `line_state_ctrl`

## Requirements
- R1: After reset the state reads 0 (Open), the one-hot output is 8'h01, both leads are high impedance, audio, ringing and supervision are disabled, both interrupt flags are 0 and irq is 0.
- R2: When st_wr is high and no fault is present, state_q takes the value of st_wdata on the next clock edge. The codes are: 0 Open, 1 forward active, 2 reverse active, 3 forward on-hook transmission, 4 reverse on-hook transmission, 5 TIP lead open, 6 RING lead open, 7 ringing. Bit n of state_onehot is 1 exactly when state_q equals n.
- R3: pol_rev is 1 in states 2, 4 and 6 and is 0 in every other state.
- R4: Both hiz_tip and hiz_ring are 1 in state 0. Only hiz_tip is 1 in state 5. Only hiz_ring is 1 in state 6. Both are 0 in all other states. sup_en is 1 in every state except 0.
- R5: audio_en is 1 only in states 1 to 4. ring_en is 1 only in state 7.
- R6: When alarm_power is high, state_q is 0 after the next clock edge. This holds whether or not the interrupt is masked, and it beats a host write in the same cycle. The state then stays at 0 until the host writes again while no fault is present.
- R7: A thermal fault occurs when temp_code is greater than THR_NORM (default 145) in any state other than 7, or greater than THR_RING (default 200) in state 7. A thermal fault forces state_q to 0 on the next clock edge. A value equal to the limit is not a fault.
- R8: irq_flags bit 0 is the power flag and bit 1 is the thermal flag. A flag is 1 after the clock edge that follows its fault. It stays 1 until a cycle in which the matching irq_clr bit is 1. If a fault and a clear arrive in the same cycle, the flag is set.
- R9: irq equals the OR of irq_flags AND NOT irq_mask, with no clock delay. The mask does not stop a flag from setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_wr | input | 1 | Host write strobe for the requested state |
| st_wdata | input | 3 | Requested state code |
| alarm_power | input | 1 | Overpower alarm |
| temp_code | input | TEMP_W | Die temperature code |
| irq_mask | input | 2 | Interrupt mask per flag (1 = masked) |
| irq_clr | input | 2 | Write-1-to-clear pulses per flag |
| state_q | output | 3 | Current state code |
| state_onehot | output | 8 | One-hot form of the current state |
| pol_rev | output | 1 | Reverse polarity (RING more positive than TIP) |
| hiz_tip | output | 1 | TIP lead high impedance |
| hiz_ring | output | 1 | RING lead high impedance |
| audio_en | output | 1 | Audio path enabled |
| ring_en | output | 1 | Ringing generator enabled |
| sup_en | output | 1 | Loop and ground-key supervision enabled |
| irq_flags | output | 2 | Sticky interrupt flags {thermal, power} |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- any power alarm or over-limit temperature leads to Open one cycle later, with the limit chosen by whether the line is ringing;
- the one-hot vector has exactly one bit set;
- Open drives both leads to high impedance with audio off, and ringing is enabled only in the ringing state;
- flags hold until they are cleared;
- irq follows the unmasked flags.

The bench scenarios show the following:
- the full decode table for every state code;
- the exact temperature boundaries at 145 and 200;
- a fault winning over a write in the same cycle;
- the state staying Open after the fault goes away;
- a set winning over a clear in the same cycle.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

   localparam int ST_W    = 3;
   localparam int NUM_ST  = 1 << ST_W;
   localparam int NUM_SRC = 2;
   localparam int SRC_PWR = 0;
   localparam int SRC_THM = 1;

   typedef enum logic [ST_W-1:0] {
      LS_OPEN     = 3'd0,
      LS_FWD_ACT  = 3'd1,
      LS_REV_ACT  = 3'd2,
      LS_FWD_OHT  = 3'd3,
      LS_REV_OHT  = 3'd4,
      LS_TIP_HIZ  = 3'd5,
      LS_RING_HIZ = 3'd6,
      LS_RINGING  = 3'd7
   } line_state_e;

   typedef struct packed {
      logic pol_rev;
      logic hiz_tip;
      logic hiz_ring;
      logic audio_en;
      logic ring_en;
      logic sup_en;
   } lead_ctl_t;

endpackage

// File: rtl/lsc_fault_detect.sv
module lsc_fault_detect
   import lsc_pkg::*;
#(
   parameter int TEMP_W   = 8,
   parameter int THR_NORM = 145,
   parameter int THR_RING = 200
) (
   input  line_state_e          state,
   input  logic [TEMP_W-1:0]    temp_code,
   input  logic                 alarm_power,
   output logic [NUM_SRC-1:0]   fault_vec
);
   localparam logic [TEMP_W-1:0] LIM_NORM = TEMP_W'(THR_NORM);
   localparam logic [TEMP_W-1:0] LIM_RING = TEMP_W'(THR_RING);

   logic [TEMP_W-1:0] limit;

   // the limit follows the registered state: raised only while ringing
   assign limit = (state == LS_RINGING) ? LIM_RING : LIM_NORM;

   always_comb begin
      fault_vec          = '0;
      fault_vec[SRC_PWR] = alarm_power;
      fault_vec[SRC_THM] = (temp_code > limit);
   end
endmodule

// File: rtl/lsc_state_reg.sv
module lsc_state_reg
   import lsc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ST_W-1:0]  wr_state,
   input  logic             fault_any,
   output line_state_e      state
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= LS_OPEN;
      else if (fault_any)
         state <= LS_OPEN;           // fault wins over a host write
      else if (wr_en)
         state <= line_state_e'(wr_state);
   end
endmodule

// File: rtl/lsc_irq.sv
module lsc_irq
   import lsc_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  set_vec,
   input  logic [NUM_SRC-1:0]  clr_vec,
   input  logic [NUM_SRC-1:0]  mask_vec,
   output logic [NUM_SRC-1:0]  flags,
   output logic                irq
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (set_vec[i])
            flags[i] <= 1'b1;        // set has priority over clear
         else if (clr_vec[i])
            flags[i] <= 1'b0;
      end
   end

   assign irq = |(flags & ~mask_vec);
endmodule

// File: rtl/lsc_decode.sv
module lsc_decode
   import lsc_pkg::*;
(
   input  line_state_e        state,
   output logic [NUM_ST-1:0]  onehot,
   output lead_ctl_t          ctl
);
   for (genvar i = 0; i < NUM_ST; i++) begin : g_oh
      assign onehot[i] = (state == line_state_e'(ST_W'(i)));
   end

   always_comb begin
      ctl          = '0;
      ctl.sup_en   = 1'b1;
      case (state)
         LS_OPEN: begin
            ctl.hiz_tip  = 1'b1;
            ctl.hiz_ring = 1'b1;
            ctl.sup_en   = 1'b0;
         end
         LS_FWD_ACT, LS_FWD_OHT: ctl.audio_en = 1'b1;
         LS_REV_ACT, LS_REV_OHT: begin
            ctl.audio_en = 1'b1;
            ctl.pol_rev  = 1'b1;
         end
         LS_TIP_HIZ:  ctl.hiz_tip = 1'b1;
         LS_RING_HIZ: begin
            ctl.hiz_ring = 1'b1;
            ctl.pol_rev  = 1'b1;
         end
         LS_RINGING:  ctl.ring_en = 1'b1;
         default: ctl = '0;
      endcase
   end
endmodule

// File: rtl/line_state_ctrl.sv
module line_state_ctrl
   import lsc_pkg::*;
#(
   parameter int TEMP_W   = 8,
   parameter int THR_NORM = 145,
   parameter int THR_RING = 200
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               st_wr,
   input  logic [2:0]         st_wdata,
   input  logic               alarm_power,
   input  logic [TEMP_W-1:0]  temp_code,
   input  logic [1:0]         irq_mask,
   input  logic [1:0]         irq_clr,
   output logic [2:0]         state_q,
   output logic [7:0]         state_onehot,
   output logic               pol_rev,
   output logic               hiz_tip,
   output logic               hiz_ring,
   output logic               audio_en,
   output logic               ring_en,
   output logic               sup_en,
   output logic [1:0]         irq_flags,
   output logic               irq
);
   initial begin : p_cfg
      AST_CFG_ORDER: assert (THR_NORM < THR_RING)
         else $fatal(1, "THR_RING must exceed THR_NORM");
      AST_CFG_RANGE: assert (THR_RING < (1 << TEMP_W))
         else $fatal(1, "THR_RING does not fit TEMP_W");
   end

   line_state_e          state;
   logic [NUM_SRC-1:0]   fault_vec;
   lead_ctl_t            ctl;

   lsc_fault_detect #(.TEMP_W(TEMP_W), .THR_NORM(THR_NORM), .THR_RING(THR_RING)) u_fault (
      .state       (state),
      .temp_code   (temp_code),
      .alarm_power (alarm_power),
      .fault_vec   (fault_vec)
   );

   lsc_state_reg u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (st_wr),
      .wr_state  (st_wdata),
      .fault_any (|fault_vec),
      .state     (state)
   );

   lsc_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (fault_vec),
      .clr_vec  (irq_clr),
      .mask_vec (irq_mask),
      .flags    (irq_flags),
      .irq      (irq)
   );

   lsc_decode u_dec (
      .state  (state),
      .onehot (state_onehot),
      .ctl    (ctl)
   );

   assign state_q  = state;
   assign pol_rev  = ctl.pol_rev;
   assign hiz_tip  = ctl.hiz_tip;
   assign hiz_ring = ctl.hiz_ring;
   assign audio_en = ctl.audio_en;
   assign ring_en  = ctl.ring_en;
   assign sup_en   = ctl.sup_en;
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
   parameter int TEMP_W   = 8,
   parameter int THR_NORM = 145,
   parameter int THR_RING = 200
) (
   input logic               clk,
   input logic               rst_n,
   input logic               st_wr,
   input logic [2:0]         st_wdata,
   input logic               alarm_power,
   input logic [TEMP_W-1:0]  temp_code,
   input logic [1:0]         irq_mask,
   input logic [1:0]         irq_clr,
   input logic [2:0]         state_q,
   input logic [7:0]         state_onehot,
   input logic               pol_rev,
   input logic               hiz_tip,
   input logic               hiz_ring,
   input logic               audio_en,
   input logic               ring_en,
   input logic               sup_en,
   input logic [1:0]         irq_flags,
   input logic               irq
);
   localparam logic [TEMP_W-1:0] LN = TEMP_W'(THR_NORM);
   localparam logic [TEMP_W-1:0] LR = TEMP_W'(THR_RING);

   AST_HOST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr && !alarm_power && temp_code <= LN |=> state_q == $past(st_wdata)); // R2
   AST_ONEHOT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_onehot) == 1); // R2
   AST_REV_POL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == 3'd2 || state_q == 3'd4) |-> pol_rev); // R3
   AST_OPEN_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == 3'd0 |-> hiz_tip && hiz_ring && !audio_en && !sup_en); // R4
   AST_RING_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ring_en |-> state_q == 3'd7); // R5
   AST_PWR_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_power |=> state_q == 3'd0); // R6
   AST_THM_NORM: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != 3'd7 && temp_code > LN |=> state_q == 3'd0); // R7
   AST_THM_RING: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == 3'd7 && temp_code > LR |=> state_q == 3'd0); // R7
   AST_PFLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_power |=> irq_flags[0]); // R8
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flags[1] && !irq_clr[1] |=> irq_flags[1]); // R8
   AST_IRQ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(irq_flags & ~irq_mask)); // R9
endmodule

bind line_state_ctrl lsc_checker #(.TEMP_W(TEMP_W), .THR_NORM(THR_NORM), .THR_RING(THR_RING)) u_chk (.*);

// File: tb/sim_line_state_ctrl.sv
`timescale 1ns/1ps
module sim_line_state_ctrl;
   localparam int TW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic st_wr = 1'b0;
   logic [2:0] st_wdata = '0;
   logic alarm_power = 1'b0;
   logic [TW-1:0] temp_code = 8'd25;
   logic [1:0] irq_mask = 2'b00;
   logic [1:0] irq_clr = 2'b00;
   logic [2:0] state_q;
   logic [7:0] state_onehot;
   logic pol_rev, hiz_tip, hiz_ring, audio_en, ring_en, sup_en;
   logic [1:0] irq_flags;
   logic irq;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   line_state_ctrl #(.TEMP_W(TW), .THR_NORM(145), .THR_RING(200)) u0 (
      .clk(clk), .rst_n(rst_n), .st_wr(st_wr), .st_wdata(st_wdata),
      .alarm_power(alarm_power), .temp_code(temp_code), .irq_mask(irq_mask),
      .irq_clr(irq_clr), .state_q(state_q), .state_onehot(state_onehot),
      .pol_rev(pol_rev), .hiz_tip(hiz_tip), .hiz_ring(hiz_ring),
      .audio_en(audio_en), .ring_en(ring_en), .sup_en(sup_en),
      .irq_flags(irq_flags), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one edge, then settle away from it
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // {pol_rev, hiz_tip, hiz_ring, audio_en, ring_en, sup_en} from the requirement table
   function automatic logic [5:0] exp_ctl(input int s);
      logic pol, ht, hr, au, rg, su;
      pol = (s == 2 || s == 4 || s == 6);
      ht  = (s == 0 || s == 5);
      hr  = (s == 0 || s == 6);
      au  = (s >= 1 && s <= 4);
      rg  = (s == 7);
      su  = (s != 0);
      return {pol, ht, hr, au, rg, su};
   endfunction

   task automatic write_state(input logic [2:0] s);
      st_wr = 1'b1;
      st_wdata = s;
      tick();
      st_wr = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 state", state_q, 0);
      check("R1 onehot", state_onehot, 8'h01);
      check("R1 leads", {pol_rev, hiz_tip, hiz_ring, audio_en, ring_en, sup_en}, 6'b011000);
      check("R1 flags", irq_flags, 0);
      check("R1 irq", irq, 0);
   endtask

   task automatic t_all_states();
      for (int s = 7; s >= 0; s--) begin
         write_state(3'(s));
         check("R2 state", state_q, s);
         check("R2 onehot", state_onehot, 8'h01 << s);
         check("R3 pol_rev", pol_rev, exp_ctl(s)[5]);
         check("R4 hiz/sup", {hiz_tip, hiz_ring, sup_en}, {exp_ctl(s)[4:3], exp_ctl(s)[0]});
         check("R5 audio/ring", {audio_en, ring_en}, exp_ctl(s)[2:1]);
      end
   endtask

   task automatic t_power();
      write_state(3'd1);
      irq_mask = 2'b01;
      alarm_power = 1'b1;
      st_wr = 1'b1;
      st_wdata = 3'd3;          // same-cycle write must lose
      tick();
      st_wr = 1'b0;
      alarm_power = 1'b0;
      check("R6 forced open", state_q, 0);
      check("R8 power flag", irq_flags, 2'b01);
      check("R9 masked irq", irq, 0);
      tick();
      tick();
      check("R6 stays open", state_q, 0);
      irq_mask = 2'b00;
      #1;
      check("R9 unmasked irq", irq, 1);
      irq_clr = 2'b01;
      tick();
      irq_clr = 2'b00;
      check("R8 cleared", irq_flags, 0);
      check("R9 irq after clear", irq, 0);
      alarm_power = 1'b1;
      irq_clr = 2'b01;
      tick();
      alarm_power = 1'b0;
      irq_clr = 2'b00;
      check("R8 set beats clear", irq_flags, 2'b01);
      irq_clr = 2'b01;
      tick();
      irq_clr = 2'b00;
      write_state(3'd4);
      check("R6 new write after fault", state_q, 4);
   endtask

   task automatic t_thermal();
      write_state(3'd1);
      temp_code = 8'd145;
      tick();
      check("R7 at normal limit", state_q, 1);
      check("R8 no thermal flag", irq_flags, 0);
      temp_code = 8'd146;
      tick();
      temp_code = 8'd25;
      check("R7 over normal limit", state_q, 0);
      check("R8 thermal flag", irq_flags, 2'b10);
      irq_clr = 2'b10;
      tick();
      irq_clr = 2'b00;
      write_state(3'd7);
      temp_code = 8'd180;
      tick();
      check("R7 ringing tolerates 180", state_q, 7);
      temp_code = 8'd200;
      tick();
      check("R7 at ringing limit", state_q, 7);
      check("R8 flag still clear", irq_flags, 0);
      temp_code = 8'd201;
      tick();
      temp_code = 8'd25;
      check("R7 over ringing limit", state_q, 0);
      check("R8 thermal flag ring", irq_flags, 2'b10);
      tick();
      check("R8 flag holds", irq_flags, 2'b10);
      check("R9 irq thermal", irq, 1);
   endtask

   initial begin : p_wd
      #(200000 * 20);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : p_main
      #35;
      rst_n = 1'b1;
      #1;
      t_reset();
      t_all_states();
      t_power();
      t_thermal();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule